// File: doc/BRIEF.md
# PS/2 Keyboard Host Port with Bus Yield

This block is the host end of a two-wire PS/2 keyboard link inside a PC system core. It receives scan-code frames from the keyboard, sends command bytes back, and acts on the shared clock and data wires only through two drive-low enables. The pad logic outside turns each enable into an open-drain pull-down. Any released wire floats high.

A second agent, such as an on-screen menu, can share the same keyboard wires. While the `intercept` input is high, the port must not pull either wire low. It still watches both wires and still decodes any frame that passes on them. The port holds the keyboard clock low after each received byte until the consumer takes it. A command transfer has a watchdog, so a keyboard that never clocks the bits out cannot hang the controller.

Both wire inputs pass through a two-stage synchronizer and a glitch filter before edge detection. All timing windows are parameters in system clock cycles. `rst_n` is asserted asynchronously and released synchronously to `clk`.

Top module: `ps2_host_port`

## Requirements
- R1: While `intercept` is high, `ps2_clk_drive_low` and `ps2_dat_drive_low` are both 0 in the same cycle, whatever the internal requests are.
- R2: A valid received frame sets `rx_valid` high and places its byte on `rx_data`. The frame has 11 bits, each taken on a filtered falling clock edge: a start bit of 0, eight data bits LSB first, a parity bit that makes the nine data and parity bits odd, and a stop bit of 1. `rx_valid` and `rx_data` stay unchanged until `rx_ack` is seen, and `rx_valid` clears on the next cycle.
- R3: While `rx_valid` is high and `intercept` is low, `ps2_clk_drive_low` is 1. The clock is released in the cycle after the acknowledge.
- R4: A frame with a wrong start bit, wrong parity or wrong stop bit gives a one-cycle pulse on `rx_error`. It does not set `rx_valid`.
- R5: The wire inputs are still sampled and decoded while `intercept` is high. A frame received then is delivered as in R2.
- R6: After a command is accepted, the port pulls the clock low with data released for exactly `INHIBIT_CYCLES` cycles. It then pulls both low for one cycle, then releases the clock while keeping data low as the start bit.
- R7: The command bits are changed after each device falling edge. The device sees eight data bits LSB first, odd parity and a released stop bit. The 11th falling edge ends the transfer with a one-cycle `tx_done` pulse.
- R8: If the device does not clock a transfer through within `TIMEOUT_CYCLES` of the request phase, the port returns to idle with both wires released and `tx_busy` low. It also gives a one-cycle `tx_timeout` pulse.
- R9: `tx_start` is ignored while `intercept` is high, while a transfer is running, while a receive frame is in progress, or while a received byte is waiting. In those cases `tx_busy` stays 0.
- R10: Reset releases both wires, clears `rx_valid`, `tx_busy` and all pulses, and drops any partial frame.
- R11: A low pulse on the clock wire that lasts fewer cycles than `FILT_LEN` is not counted as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, async assert, sync release |
| intercept | input | 1 | High while another agent owns the keyboard wires |
| ps2_clk_in | input | 1 | Level sensed on the shared clock wire |
| ps2_dat_in | input | 1 | Level sensed on the shared data wire |
| ps2_clk_drive_low | output | 1 | Pull the clock wire low when 1 |
| ps2_dat_drive_low | output | 1 | Pull the data wire low when 1 |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | Received byte waiting for the consumer |
| rx_ack | input | 1 | Consumer takes the waiting byte |
| rx_error | output | 1 | One-cycle pulse on a malformed frame |
| tx_data | input | 8 | Command byte to send |
| tx_start | input | 1 | Request to send `tx_data` |
| tx_busy | output | 1 | Command transfer in progress |
| tx_done | output | 1 | One-cycle pulse when a transfer completes |
| tx_timeout | output | 1 | One-cycle pulse when a transfer is abandoned |

## Verification
A receive bit counter that is off by one shows up within one frame. The frame after it is then misaligned, so the next byte either arrives wrong on `rx_data` or produces an `rx_error`. A transmit sequencer stuck outside idle keeps `tx_busy` high. It also keeps a drive-low enable active past the inhibit window, and this is visible within `INHIBIT_CYCLES` plus one cycle. A gating fault shows in the same cycle as a drive-low enable that is 1 while `intercept` is high. A lost timeout shows as a missing `tx_timeout` pulse after the watchdog window.

// File: rtl/ps2_host_pkg.sv
package ps2_host_pkg;

  localparam int FRAME_BITS = 11;
  localparam int BIT_CNT_W  = 4;

  typedef enum logic [1:0] {
    TX_IDLE    = 2'd0,
    TX_INHIBIT = 2'd1,
    TX_REQ     = 2'd2,
    TX_SHIFT   = 2'd3
  } tx_state_t;

  // parity bit chosen so data plus parity carry an odd count of ones
  function automatic logic odd_parity(input logic [7:0] d);
    return ~(^d);
  endfunction

endpackage

// File: rtl/ps2_line_filter.sv
module ps2_line_filter #(
  parameter int FILT_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic level,
  output logic fall
);

  logic [1:0]          sync_q;
  logic [FILT_LEN-1:0] hist_q;
  logic                level_q, level_d;
  logic                fall_q, fall_d;

  // level moves only when every sample in the history agrees
  always_comb begin
    level_d = level_q;
    if (&hist_q)       level_d = 1'b1;
    else if (~|hist_q) level_d = 1'b0;
    fall_d = level_q & ~level_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      hist_q  <= '1;
      level_q <= 1'b1;
      fall_q  <= 1'b0;
    end else begin
      sync_q  <= {sync_q[0], line_in};
      hist_q  <= {hist_q[FILT_LEN-2:0], sync_q[1]};
      level_q <= level_d;
      fall_q  <= fall_d;
    end
  end

  assign level = level_q;
  assign fall  = fall_q;

endmodule

// File: rtl/ps2_rx_frame.sv
module ps2_rx_frame
  import ps2_host_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       fall,
  input  logic       dat_level,
  input  logic       ack,
  output logic [7:0] data,
  output logic       valid,
  output logic       error,
  output logic       busy
);

  localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(FRAME_BITS - 1);

  logic [9:0]           bits_q, bits_d;
  logic [BIT_CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]           data_q, data_d;
  logic                 valid_q, valid_d;
  logic                 err_q, err_d;
  logic                 bit_en;
  logic                 frame_ok;

  assign bit_en   = fall & enable & ~valid_q;
  // bits_q[0]=start, [8:1]=data, [9]=parity; dat_level is the stop bit
  assign frame_ok = ~bits_q[0] & dat_level & (^bits_q[9:1]);

  always_comb begin
    bits_d  = bits_q;
    cnt_d   = cnt_q;
    data_d  = data_q;
    valid_d = valid_q;
    err_d   = 1'b0;
    if (!enable) begin
      cnt_d = '0;
    end else if (bit_en) begin
      if (cnt_q == LAST_BIT) begin
        cnt_d = '0;
        if (frame_ok) begin
          valid_d = 1'b1;
          data_d  = bits_q[8:1];
        end else begin
          err_d = 1'b1;
        end
      end else begin
        bits_d = {dat_level, bits_q[9:1]};
        cnt_d  = cnt_q + 1'b1;
      end
    end
    if (valid_q && ack) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q  <= '0;
      cnt_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      bits_q  <= bits_d;
      cnt_q   <= cnt_d;
      data_q  <= data_d;
      valid_q <= valid_d;
      err_q   <= err_d;
    end
  end

  assign data  = data_q;
  assign valid = valid_q;
  assign error = err_q;
  assign busy  = (cnt_q != '0);

endmodule

// File: rtl/ps2_tx_frame.sv
module ps2_tx_frame
  import ps2_host_pkg::*;
#(
  parameter int INHIBIT_CYCLES = 12000,
  parameter int TIMEOUT_CYCLES = 1500000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] data,
  input  logic       fall,
  output logic       clk_req,
  output logic       dat_req,
  output logic       busy,
  output logic       done,
  output logic       timeout
);

  localparam int MAXC = (INHIBIT_CYCLES > TIMEOUT_CYCLES) ? INHIBIT_CYCLES : TIMEOUT_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0]        INH_LAST = CW'(INHIBIT_CYCLES - 1);
  localparam logic [CW-1:0]        TO_LAST  = CW'(TIMEOUT_CYCLES - 1);
  localparam logic [BIT_CNT_W-1:0] END_BIT  = BIT_CNT_W'(FRAME_BITS - 1);

  tx_state_t            state_q, state_d;
  logic [CW-1:0]        cnt_q, cnt_d;
  logic [9:0]           shreg_q, shreg_d;
  logic [BIT_CNT_W-1:0] bit_q, bit_d;
  logic                 txbit_q, txbit_d;
  logic                 done_q, done_d;
  logic                 to_q, to_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shreg_d = shreg_q;
    bit_d   = bit_q;
    txbit_d = txbit_q;
    done_d  = 1'b0;
    to_d    = 1'b0;
    unique case (state_q)
      TX_IDLE: begin
        if (start) begin
          state_d = TX_INHIBIT;
          cnt_d   = '0;
          shreg_d = {1'b1, odd_parity(data), data};
        end
      end
      TX_INHIBIT: begin
        if (cnt_q == INH_LAST) begin
          state_d = TX_REQ;
          cnt_d   = '0;
          bit_d   = '0;
          txbit_d = 1'b0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      TX_REQ: begin
        state_d = TX_SHIFT;
        cnt_d   = cnt_q + 1'b1;
      end
      TX_SHIFT: begin
        if (cnt_q == TO_LAST) begin
          state_d = TX_IDLE;
          txbit_d = 1'b1;
          to_d    = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
          if (fall) begin
            if (bit_q == END_BIT) begin
              state_d = TX_IDLE;
              txbit_d = 1'b1;
              done_d  = 1'b1;
            end else begin
              txbit_d = shreg_q[bit_q];
              bit_d   = bit_q + 1'b1;
            end
          end
        end
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      cnt_q   <= '0;
      shreg_q <= '0;
      bit_q   <= '0;
      txbit_q <= 1'b1;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      bit_q   <= bit_d;
      txbit_q <= txbit_d;
      done_q  <= done_d;
      to_q    <= to_d;
    end
  end

  assign clk_req = (state_q == TX_INHIBIT) || (state_q == TX_REQ);
  assign dat_req = ((state_q == TX_REQ) || (state_q == TX_SHIFT)) && !txbit_q;
  assign busy    = (state_q != TX_IDLE);
  assign done    = done_q;
  assign timeout = to_q;

endmodule

// File: rtl/ps2_host_port.sv
module ps2_host_port #(
  parameter int INHIBIT_CYCLES = 12000,
  parameter int TIMEOUT_CYCLES = 1500000,
  parameter int FILT_LEN       = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       intercept,
  input  logic       ps2_clk_in,
  input  logic       ps2_dat_in,
  output logic       ps2_clk_drive_low,
  output logic       ps2_dat_drive_low,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_ack,
  output logic       rx_error,
  input  logic [7:0] tx_data,
  input  logic       tx_start,
  output logic       tx_busy,
  output logic       tx_done,
  output logic       tx_timeout
);

  localparam int NLINES = 2;
  localparam int L_CLK  = 0;
  localparam int L_DAT  = 1;

  logic [NLINES-1:0] line_raw, line_lvl, line_fall;
  logic rx_busy_w, tx_go, clk_req, tx_clk_req, tx_dat_req;

  assign line_raw[L_CLK] = ps2_clk_in;
  assign line_raw[L_DAT] = ps2_dat_in;

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    ps2_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_in (line_raw[g]),
      .level   (line_lvl[g]),
      .fall    (line_fall[g])
    );
  end

  ps2_rx_frame u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (~tx_busy),
    .fall      (line_fall[L_CLK]),
    .dat_level (line_lvl[L_DAT]),
    .ack       (rx_ack),
    .data      (rx_data),
    .valid     (rx_valid),
    .error     (rx_error),
    .busy      (rx_busy_w)
  );

  // a command may only start on a quiet, owned, empty link
  assign tx_go = tx_start & ~intercept & ~tx_busy & ~rx_valid & ~rx_busy_w;

  ps2_tx_frame #(
    .INHIBIT_CYCLES (INHIBIT_CYCLES),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tx_go),
    .data    (tx_data),
    .fall    (line_fall[L_CLK]),
    .clk_req (tx_clk_req),
    .dat_req (tx_dat_req),
    .busy    (tx_busy),
    .done    (tx_done),
    .timeout (tx_timeout)
  );

  assign clk_req           = tx_clk_req | rx_valid;
  assign ps2_clk_drive_low = clk_req & ~intercept;
  assign ps2_dat_drive_low = tx_dat_req & ~intercept;

endmodule

// File: rtl/ps2_host_port_chk.sv
module ps2_host_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       intercept,
  input logic       ps2_clk_drive_low,
  input logic       ps2_dat_drive_low,
  input logic [7:0] rx_data,
  input logic       rx_valid,
  input logic       rx_ack,
  input logic       rx_error,
  input logic       tx_busy,
  input logic       tx_done,
  input logic       tx_timeout
);

  p_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    intercept |-> (!ps2_clk_drive_low && !ps2_dat_drive_low));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ack) |=> (rx_valid && $stable(rx_data)));

  p_inhibit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !intercept) |-> ps2_clk_drive_low);

  p_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ack) |=> !rx_valid);

  p_err_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_error |=> !rx_error);

  p_err_novalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_error |-> !rx_valid);

  p_to_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_timeout |-> (!tx_busy && !ps2_clk_drive_low && !ps2_dat_drive_low && !tx_done));

  p_to_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_timeout |=> !tx_timeout);

  p_no_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && (intercept || rx_valid)) |=> !tx_busy);

  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && tx_busy));

endmodule

bind ps2_host_port ps2_host_port_chk u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .intercept         (intercept),
  .ps2_clk_drive_low (ps2_clk_drive_low),
  .ps2_dat_drive_low (ps2_dat_drive_low),
  .rx_data           (rx_data),
  .rx_valid          (rx_valid),
  .rx_ack            (rx_ack),
  .rx_error          (rx_error),
  .tx_busy           (tx_busy),
  .tx_done           (tx_done),
  .tx_timeout        (tx_timeout)
);

// File: tb/ps2_host_port_test.sv
module ps2_host_port_test;

  localparam int INH  = 200;
  localparam int TOUT = 3000;
  localparam int FILT = 4;
  localparam int HALF = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic intercept = 1'b0;
  logic kb_clk = 1'b1, kb_dat = 1'b1;
  logic ps2_clk_in, ps2_dat_in, ps2_clk_drive_low, ps2_dat_drive_low;
  logic [7:0] rx_data, tx_data = 8'h00;
  logic rx_valid, rx_ack = 1'b0, rx_error;
  logic tx_start = 1'b0, tx_busy, tx_done, tx_timeout;

  always #5 clk = ~clk;

  assign ps2_clk_in = kb_clk & ~ps2_clk_drive_low;
  assign ps2_dat_in = kb_dat & ~ps2_dat_drive_low;

  ps2_host_port #(.INHIBIT_CYCLES(INH), .TIMEOUT_CYCLES(TOUT), .FILT_LEN(FILT)) uut (
    .clk(clk), .rst_n(rst_n), .intercept(intercept),
    .ps2_clk_in(ps2_clk_in), .ps2_dat_in(ps2_dat_in),
    .ps2_clk_drive_low(ps2_clk_drive_low), .ps2_dat_drive_low(ps2_dat_drive_low),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ack(rx_ack), .rx_error(rx_error),
    .tx_data(tx_data), .tx_start(tx_start), .tx_busy(tx_busy),
    .tx_done(tx_done), .tx_timeout(tx_timeout));

  typedef struct {
    byte        kind;
    logic [7:0] data;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int vectors = 0;
  int miscompares = 0;
  bit reported = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  task automatic expect_ev(input byte kind, input logic [7:0] d, input string req);
    exp_t e;
    e.kind = kind; e.data = d; e.req = req;
    exp_q.push_back(e);
  endtask

  // monitor: pops the scoreboard as results appear
  task automatic score(input byte kind, input logic [7:0] d);
    exp_t e;
    if (exp_q.size() == 0) begin
      chk(1'b0, "unexpected event", int'(kind), 0);
    end else begin
      e = exp_q.pop_front();
      chk(e.kind == kind && e.data == d, e.req, {kind, d}, {e.kind, e.data});
    end
  endtask

  logic prev_valid = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid && !prev_valid) score("V", rx_data);
      if (rx_error)   score("E", 8'h00);
      if (tx_done)    score("D", 8'h00);
      if (tx_timeout) score("T", 8'h00);
    end
    prev_valid = rx_valid && rst_n;
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // mode 0 good, 1 bad parity, 2 bad stop, 3 bad start
  task automatic kb_send(input logic [7:0] d, input int mode);
    logic [10:0] fr;
    fr = {1'b1, ~(^d), d, 1'b0};
    if (mode == 1) fr[9]  = ~fr[9];
    if (mode == 2) fr[10] = 1'b0;
    if (mode == 3) fr[0]  = 1'b1;
    for (int i = 0; i < 11; i++) begin
      kb_dat = fr[i];
      cyc(HALF);
      kb_clk = 1'b0;
      cyc(HALF);
      kb_clk = 1'b1;
    end
    cyc(HALF);
    kb_dat = 1'b1;
    cyc(10);
  endtask

  task automatic ack_byte();
    rx_ack = 1'b1;
    cyc(1);
    rx_ack = 1'b0;
  endtask

  task automatic pulse_tx(input logic [7:0] d);
    tx_data = d;
    tx_start = 1'b1;
    cyc(1);
    tx_start = 1'b0;
  endtask

  // device side of a host-to-device command
  task automatic kb_receive(input logic [7:0] d);
    int n;
    logic [9:0] got;
    n = 0;
    while (ps2_clk_drive_low && !ps2_dat_drive_low && n < 10 * INH) begin
      n++;
      cyc(1);
    end
    chk(n == INH, "R6 inhibit length", n, INH);
    chk(ps2_clk_drive_low && ps2_dat_drive_low, "R6 request phase",
        {ps2_clk_drive_low, ps2_dat_drive_low}, 3);
    cyc(1);
    chk(!ps2_clk_drive_low && ps2_dat_in == 1'b0, "R6 clock released with start bit",
        {ps2_clk_drive_low, ps2_dat_in}, 0);
    for (int k = 1; k <= 11; k++) begin
      if (k == 11) kb_dat = 1'b0;
      cyc(HALF);
      kb_clk = 1'b0;
      cyc(HALF);
      if (k <= 10) got[k-1] = ps2_dat_in;
      kb_clk = 1'b1;
    end
    cyc(HALF);
    kb_dat = 1'b1;
    chk(got[7:0] == d, "R7 data bits", got[7:0], d);
    chk(got[8] == ~(^d), "R7 odd parity", got[8], ~(^d));
    chk(got[9] == 1'b1, "R7 stop released", got[9], 1);
    cyc(10);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    report();
  end

  initial begin
    cyc(3);
    // R10 reset state
    chk(!ps2_clk_drive_low && !ps2_dat_drive_low && !rx_valid && !tx_busy && !rx_error,
        "R10 reset state", {ps2_clk_drive_low, ps2_dat_drive_low, rx_valid, tx_busy}, 0);
    rst_n = 1'b1;
    cyc(10);

    // R2/R3 basic receive and hold
    expect_ev("V", 8'hA5, "R2 byte A5");
    kb_send(8'hA5, 0);
    chk(rx_valid && ps2_clk_drive_low, "R3 clock held while byte waits",
        {rx_valid, ps2_clk_drive_low}, 3);
    cyc(30);
    chk(rx_valid && rx_data == 8'hA5, "R2 byte held until ack", rx_data, 8'hA5);
    intercept = 1'b1;
    cyc(1);
    chk(!ps2_clk_drive_low && !ps2_dat_drive_low, "R1 gate during inhibit",
        ps2_clk_drive_low, 0);
    intercept = 1'b0;
    cyc(1);
    chk(ps2_clk_drive_low, "R3 inhibit resumes", ps2_clk_drive_low, 1);
    ack_byte();
    chk(!rx_valid && !ps2_clk_drive_low, "R3 release after ack",
        {rx_valid, ps2_clk_drive_low}, 0);
    cyc(20);

    // R5 receive while intercepted
    intercept = 1'b1;
    expect_ev("V", 8'h3C, "R5 byte during intercept");
    kb_send(8'h3C, 0);
    chk(rx_valid && !ps2_clk_drive_low, "R1 no inhibit while intercepted",
        {rx_valid, ps2_clk_drive_low}, 2);
    ack_byte();
    intercept = 1'b0;
    cyc(20);

    // R2 more patterns
    expect_ev("V", 8'h00, "R2 byte 00");
    kb_send(8'h00, 0);
    ack_byte();
    cyc(20);
    expect_ev("V", 8'hFF, "R2 byte FF");
    kb_send(8'hFF, 0);
    ack_byte();
    cyc(20);

    // R4 malformed frames
    expect_ev("E", 8'h00, "R4 bad parity");
    kb_send(8'h6B, 1);
    chk(!rx_valid, "R4 no byte on bad parity", rx_valid, 0);
    cyc(20);
    expect_ev("E", 8'h00, "R4 bad stop");
    kb_send(8'h12, 2);
    chk(!rx_valid && !ps2_clk_drive_low, "R4 no byte on bad stop", rx_valid, 0);
    cyc(20);
    expect_ev("E", 8'h00, "R4 bad start");
    kb_send(8'h34, 3);
    chk(!rx_valid, "R4 no byte on bad start", rx_valid, 0);
    cyc(20);

    // R11 short glitch on clock then a good frame
    kb_clk = 1'b0;
    cyc(FILT - 2);
    kb_clk = 1'b1;
    cyc(20);
    expect_ev("V", 8'h5A, "R11 glitch ignored");
    kb_send(8'h5A, 0);
    ack_byte();
    cyc(20);

    // R6/R7 command transfer
    expect_ev("D", 8'h00, "R7 transfer done");
    pulse_tx(8'hED);
    chk(tx_busy, "R6 command accepted", tx_busy, 1);
    kb_receive(8'hED);
    chk(!tx_busy && !ps2_clk_drive_low && !ps2_dat_drive_low, "R7 idle after transfer",
        {tx_busy, ps2_clk_drive_low, ps2_dat_drive_low}, 0);
    cyc(20);

    // R9 start ignored under intercept
    intercept = 1'b1;
    pulse_tx(8'hF4);
    cyc(100);
    chk(!tx_busy && !ps2_clk_drive_low && !ps2_dat_drive_low, "R9 start ignored under intercept",
        {tx_busy, ps2_clk_drive_low, ps2_dat_drive_low}, 0);
    intercept = 1'b0;
    cyc(10);

    // R9 start ignored while a byte waits
    expect_ev("V", 8'h11, "R2 byte 11");
    kb_send(8'h11, 0);
    pulse_tx(8'hFF);
    cyc(5);
    chk(!tx_busy && !ps2_dat_drive_low, "R9 start ignored while byte waits", tx_busy, 0);
    ack_byte();
    cyc(20);
    chk(!tx_busy, "R9 no deferred start", tx_busy, 0);

    // R8 timeout with silent device
    begin
      int n;
      n = 0;
      expect_ev("T", 8'h00, "R8 timeout pulse");
      pulse_tx(8'hEE);
      while (!tx_timeout && n < 3 * (INH + TOUT)) begin
        n++;
        cyc(1);
      end
      chk(tx_timeout && !tx_busy && !ps2_clk_drive_low && !ps2_dat_drive_low,
          "R8 released on timeout", {tx_timeout, tx_busy, ps2_clk_drive_low, ps2_dat_drive_low}, 8);
      chk(n >= TOUT && n <= INH + TOUT + 2, "R8 timeout window", n, INH + TOUT);
      cyc(1);
      chk(!tx_timeout, "R8 timeout is one cycle", tx_timeout, 0);
    end
    cyc(20);

    // R10 reset while a byte waits
    expect_ev("V", 8'h22, "R2 byte 22");
    kb_send(8'h22, 0);
    chk(ps2_clk_drive_low, "R3 inhibit before reset", ps2_clk_drive_low, 1);
    rst_n = 1'b0;
    cyc(2);
    chk(!rx_valid && !ps2_clk_drive_low && !ps2_dat_drive_low && !tx_busy,
        "R10 reset clears held byte", {rx_valid, ps2_clk_drive_low}, 0);
    rst_n = 1'b1;
    cyc(20);

    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    report();
  end

endmodule